// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block sits after a PWM time base. Each clock it takes the running count, the count direction, and single-cycle strobes that mark the counter reaching zero and reaching its period. From these it drives two PWM pins, A and B. Two 16-bit compare slots, one per channel, produce match events. Each compare slot either takes a written value at once, or holds it in a shadow copy until a chosen load point in the count cycle.

Each pin has an action table. For each of three events the table gives a 2-bit code that leaves the pin alone, drives it low, drives it high, or inverts it. The three events are the counter at zero, compare A matching while counting up, and compare B matching while counting up. A force register can pin either output to a fixed level, and the pin then ignores its events. Software programs the block through a one-cycle write strobe with an address and 16 data bits.

Register addresses: 0 compare control, 1 compare A, 2 compare B, 3 pin A actions, 4 pin B actions, 5 force.

Top module: `pwm_cmp_aq`

## Requirements
- R1: After reset both pins are low, and every compare value, action field and force field is zero.
- R2: An action code of 0 leaves the pin unchanged, 1 drives it low, 2 drives it high and 3 inverts it. In an action register, bits 1:0 hold the zero-event action, bits 5:4 the compare-A-up action and bits 9:8 the compare-B-up action. A pin changes at the clock edge that samples its event.
- R3: A compare event occurs only when the up-direction input is high and the count equals that slot's active compare value. While the direction input is low, no compare event occurs.
- R4: If several events with a non-zero action code occur on the same tick, only one is applied. Compare B wins over compare A, and either compare wins over zero. An event whose code is 0 does not block an event of lower priority.
- R5: In immediate mode (compare control bit 4 clear for A, bit 6 clear for B), a written compare value is used for matching from the following cycle.
- R6: In shadow mode (bit 4 or bit 6 set), a write goes to the shadow copy. The shadow copy is transferred to the active value at the load point given by bits 1:0 (slot A) or bits 3:2 (slot B): 0 on the zero strobe, 1 on the period strobe, 2 on either strobe, 3 never.
- R7: The force register holds bits 1:0 for pin A and bits 3:2 for pin B. Code 1 holds the pin low and code 2 holds it high, starting in the cycle after the write. While forced, the pin's events have no effect. Codes 0 and 3 do not force.
- R8: When forcing is released, the pin keeps the forced level until its next event with a non-zero action.
- R9: With zero-set and compare-up-clear actions, a pin is high for as many ticks as its compare value. A compare value of 0 gives a pin that stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_cnt | input | 16 | Time-base count |
| tb_up | input | 1 | High while the time base counts up |
| tb_zero | input | 1 | Strobe: count is at zero this tick |
| tb_prd | input | 1 | Strobe: count is at period this tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| out_a | output | 1 | PWM pin A |
| out_b | output | 1 | PWM pin B |

## Verification
The hardest case to reach from the ports is a shadowed compare write that lands mid-period and must wait for the right strobe. The bench writes the shadow between strobes for each of the four load-point codes, including freeze, and observes the pin edge move only at the selected strobe. Events that collide on one tick are produced by programming both compare slots, or a compare slot and zero, to the same count. Release of forcing is done mid-period, so the held level can be told apart from the level the next event would produce.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int NCH     = 2;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TBL0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FRC   = 3'd5;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_TOG  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PRD    = 2'd1,
        LD_EITHER = 2'd2,
        LD_FREEZE = 2'd3
    } ldpt_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'd0,
        FRC_LOW  = 2'd1,
        FRC_HIGH = 2'd2,
        FRC_RSVD = 2'd3
    } frc_e;

    typedef struct packed {
        act_e on_cmpb;
        act_e on_cmpa;
        act_e on_zero;
    } act_tbl_t;

    function automatic logic act_apply(input logic cur, input act_e a);
        unique case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_TOG:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_cmp_slot.sv
module pwm_cmp_slot
    import pwm_aq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shadow_en,
    input  ldpt_e         ldpt,
    input  logic          tb_zero,
    input  logic          tb_prd,
    input  logic          tb_up,
    input  logic [CW-1:0] cnt,
    input  logic          wr_hit,
    input  logic [CW-1:0] wr_val,
    output logic          hit
);

    typedef struct packed {
        logic [CW-1:0] shadow;
        logic [CW-1:0] active;
    } slot_t;

    slot_t s_d, s_q;
    logic  load_pt;

    always_comb begin
        unique case (ldpt)
            LD_ZERO:   load_pt = tb_zero;
            LD_PRD:    load_pt = tb_prd;
            LD_EITHER: load_pt = tb_zero | tb_prd;
            default:   load_pt = 1'b0;
        endcase
        s_d = s_q;
        if (shadow_en && load_pt) begin
            s_d.active = s_q.shadow;
        end
        if (wr_hit) begin
            s_d.shadow = wr_val;
            if (!shadow_en) begin
                s_d.active = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit = tb_up && (cnt == s_q.active);

    assert_immediate_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_en && wr_hit) |=> (s_q.active == $past(wr_val)));

    assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en && ldpt == LD_FREEZE) |=> $stable(s_q.active));

endmodule

// File: rtl/pwm_aq_lane.sv
module pwm_aq_lane
    import pwm_aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  act_tbl_t   tbl,
    input  logic       ev_zero,
    input  logic       ev_cmpa,
    input  logic       ev_cmpb,
    input  logic [1:0] frc,
    output logic       pin
);

    typedef struct packed {
        logic level;
    } lane_t;

    lane_t l_d, l_q;
    logic  forced;
    logic  frc_lvl;
    act_e  pick;

    always_comb begin
        forced  = (frc_e'(frc) == FRC_LOW) || (frc_e'(frc) == FRC_HIGH);
        frc_lvl = (frc_e'(frc) == FRC_HIGH);

        // lowest priority first, later assignments override
        pick = ACT_NONE;
        if (ev_zero && tbl.on_zero != ACT_NONE) pick = tbl.on_zero;
        if (ev_cmpa && tbl.on_cmpa != ACT_NONE) pick = tbl.on_cmpa;
        if (ev_cmpb && tbl.on_cmpb != ACT_NONE) pick = tbl.on_cmpb;

        l_d = l_q;
        if (forced) begin
            l_d.level = frc_lvl;
        end else begin
            l_d.level = act_apply(l_q.level, pick);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign pin = forced ? frc_lvl : l_q.level;

    assert_release_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(forced) && !forced) |-> (pin == $past(pin)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced && !ev_zero && !ev_cmpa && !ev_cmpb) |=> (l_q.level == $past(l_q.level)));

    assert_cmp_beats_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced && ev_cmpa && tbl.on_cmpa == ACT_LOW &&
         !(ev_cmpb && tbl.on_cmpb != ACT_NONE)) |=> !l_q.level);

endmodule

// File: rtl/pwm_cmp_aq.sv
module pwm_cmp_aq
    import pwm_aq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tb_cnt,
    input  logic              tb_up,
    input  logic              tb_zero,
    input  logic              tb_prd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_a,
    output logic              out_b
);

    localparam int CTL_SH_BASE = 4;

    typedef struct packed {
        logic [CTL_SH_BASE+2*NCH-1:0] ctl;
        act_tbl_t [NCH-1:0]           tbl;
        logic [2*NCH-1:0]             frc;
    } regs_t;

    regs_t r_d, r_q;

    logic [NCH-1:0] cmp_hit;
    logic [NCH-1:0] pin;
    logic           unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DATA_W-1:10], wr_data[7:6], wr_data[3:2]};

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == A_CTL) begin
                r_d.ctl = wr_data[CTL_SH_BASE+2*NCH-1:0];
            end
            if (wr_addr == A_FRC) begin
                r_d.frc = wr_data[2*NCH-1:0];
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == A_TBL0 + ADDR_W'(i)) begin
                    r_d.tbl[i].on_zero = act_e'(wr_data[1:0]);
                    r_d.tbl[i].on_cmpa = act_e'(wr_data[5:4]);
                    r_d.tbl[i].on_cmpb = act_e'(wr_data[9:8]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        pwm_cmp_slot #(.CW(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .shadow_en (r_q.ctl[CTL_SH_BASE + 2*g]),
            .ldpt      (ldpt_e'(r_q.ctl[2*g +: 2])),
            .tb_zero   (tb_zero),
            .tb_prd    (tb_prd),
            .tb_up     (tb_up),
            .cnt       (tb_cnt),
            .wr_hit    (wr_en && wr_addr == A_CMP0 + ADDR_W'(g)),
            .wr_val    (wr_data),
            .hit       (cmp_hit[g])
        );
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        pwm_aq_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .tbl     (r_q.tbl[g]),
            .ev_zero (tb_zero),
            .ev_cmpa (cmp_hit[0]),
            .ev_cmpb (cmp_hit[1]),
            .frc     (r_q.frc[2*g +: 2]),
            .pin     (pin[g])
        );
    end

    assign out_a = pin[0];
    assign out_b = pin[1];

    assert_force_low_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FRC && wr_data[1:0] == 2'd1) |=> !out_a);

    assert_no_cmp_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_up && !tb_zero && r_q.frc == '0) |=> (out_a == $past(out_a) && out_b == $past(out_b)));

endmodule

// File: tb/pwm_cmp_aq_bench.sv
`timescale 1ns/1ps
module pwm_cmp_aq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_cnt = '0;
    logic        tb_up = 1'b0;
    logic        tb_zero = 1'b0;
    logic        tb_prd = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_a;
    logic        out_b;

    always #2.5 clk = ~clk;

    pwm_cmp_aq u_pwm_cmp_aq (
        .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .tb_up(tb_up),
        .tb_zero(tb_zero), .tb_prd(tb_prd), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_a(out_a), .out_b(out_b)
    );

    typedef struct {
        logic  a;
        logic  b;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;

    // reference state derived from the requirements
    logic [15:0] m_act [2];
    logic [15:0] m_sh  [2];
    logic [15:0] m_tbl [2];
    logic [15:0] m_ctl;
    logic [3:0]  m_frc;
    logic        m_st  [2];
    int          tcnt = 0;
    int          tprd = 9;
    bit          tup = 1'b1;
    string       tag = "R1";

    function automatic logic apply_code(logic cur, logic [1:0] c);
        case (c)
            2'd1: return 1'b0;
            2'd2: return 1'b1;
            2'd3: return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic step(bit we = 0, int addr = 0, int dat = 0);
        bit z, p;
        logic ev[2];
        logic [1:0] f;
        logic [1:0] code;
        logic [15:0] nact[2];
        z = (tcnt == 0);
        p = (tcnt == tprd);
        tb_cnt = 16'(tcnt); tb_up = tup; tb_zero = z; tb_prd = p;
        wr_en = we; wr_addr = 3'(addr); wr_data = 16'(dat);
        for (int i = 0; i < 2; i++) ev[i] = tup && (16'(tcnt) == m_act[i]);
        for (int c = 0; c < 2; c++) begin
            f = m_frc[2*c +: 2];
            if (f == 2'd1 || f == 2'd2) begin
                m_st[c] = (f == 2'd2);
            end else begin
                code = 2'd0;
                if (z && m_tbl[c][1:0] != 0) code = m_tbl[c][1:0];
                if (ev[0] && m_tbl[c][5:4] != 0) code = m_tbl[c][5:4];
                if (ev[1] && m_tbl[c][9:8] != 0) code = m_tbl[c][9:8];
                m_st[c] = apply_code(m_st[c], code);
            end
        end
        for (int i = 0; i < 2; i++) begin
            bit sh, ld;
            logic [1:0] lp;
            sh = m_ctl[4 + 2*i];
            lp = m_ctl[2*i +: 2];
            ld = sh && ((lp == 0 && z) || (lp == 1 && p) || (lp == 2 && (z || p)));
            nact[i] = ld ? m_sh[i] : m_act[i];
            if (we && addr == 1 + i) begin
                m_sh[i] = 16'(dat);
                if (!sh) nact[i] = 16'(dat);
            end
            m_act[i] = nact[i];
        end
        if (we && addr == 0) m_ctl = 16'(dat) & 16'h007F;
        if (we && addr == 3) m_tbl[0] = 16'(dat) & 16'h0333;
        if (we && addr == 4) m_tbl[1] = 16'(dat) & 16'h0333;
        if (we && addr == 5) m_frc = 4'(dat);
        begin
            exp_t e;
            logic o[2];
            for (int c = 0; c < 2; c++) begin
                f = m_frc[2*c +: 2];
                o[c] = (f == 2'd1 || f == 2'd2) ? (f == 2'd2) : m_st[c];
            end
            e.a = o[0]; e.b = o[1]; e.tag = tag;
            exp_q.push_back(e);
        end
        if (tup) tcnt = (tcnt == tprd) ? 0 : tcnt + 1;
        else     tcnt = (tcnt == 0) ? tprd : tcnt - 1;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    // monitor: compares each pushed expectation one cycle later
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (out_a !== e.a || out_b !== e.b) begin
                fails++;
                $display("FAIL %s t=%0t actual a=%b b=%b expected a=%b b=%b",
                         e.tag, $time, out_a, out_b, e.a, e.b);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_act[i] = '0; m_sh[i] = '0; m_tbl[i] = '0; m_st[i] = 1'b0;
        end
        m_ctl = '0; m_frc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: pins low out of reset
        checks++;
        if (out_a !== 1'b0 || out_b !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual a=%b b=%b expected a=0 b=0", out_a, out_b);
        end
        tag = "R1"; run(12);

        // R9 / R2: normal polarity duty on both pins
        tag = "R9";
        step(1, 3, 16'h0012); step(1, 4, 16'h0102);
        step(1, 1, 3); step(1, 2, 6);
        run(25);
        // R9: compare 0 gives constant low
        step(1, 1, 0); run(25);

        // R2: toggle codes
        tag = "R2";
        step(1, 1, 3); step(1, 3, 16'h0003); step(1, 4, 16'h0030);
        run(25);

        // R4: collisions
        tag = "R4";
        step(1, 3, 16'h0212); step(1, 4, 16'h0012);
        step(1, 1, 4); step(1, 2, 4);
        run(22);
        step(1, 2, 7); run(22);
        step(1, 3, 16'h0012); step(1, 2, 0); step(1, 1, 0); run(22);

        // R3: down counting produces no compare events
        tag = "R3";
        step(1, 1, 3); step(1, 2, 6);
        tup = 1'b0; run(25); tup = 1'b1;
        run(12);

        // R5: immediate mid-period rewrites
        tag = "R5";
        run(2); step(1, 1, 5); run(7); step(1, 2, 2); run(14);

        // R6: shadow load points
        tag = "R6";
        step(1, 0, 16'h0010); run(2); step(1, 1, 2); run(20);
        step(1, 0, 16'h0011); run(2); step(1, 1, 6); run(20);
        step(1, 0, 16'h0012); run(3); step(1, 1, 8); run(20);
        step(1, 0, 16'h0013); run(1); step(1, 1, 1); run(20);
        step(1, 0, 16'h0044); run(2); step(1, 2, 8); run(20);
        step(1, 0, 16'h0000); run(12);

        // R7: forcing overrides events
        tag = "R7";
        step(1, 5, 16'h0002); run(15);
        step(1, 5, 16'h0004); run(15);
        step(1, 5, 16'h0009); run(15);
        step(1, 5, 16'h000F); run(15);

        // R8: release mid-period keeps forced level
        tag = "R8";
        step(1, 5, 16'h0006); run(4);
        step(1, 5, 16'h0000); run(20);

        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule